// File: doc/BRIEF.md
# Asynchronous Static Memory Timing Sequencer

This block sits between an on-chip requester and an external SRAM, ROM or asynchronous NOR flash. It turns one host request into one complete external bus cycle, made of address setup, an optional address hold, and data setup, followed after reads on a shared address/data bus by an idle turnaround gap. It can serve up to four external devices. Each device is reached through its own region, and each region keeps a control word and a shared read/write timing word. A region may also keep a separate write timing word.

Configuration is loaded through a plain register port. Within a region, slot 0 is the control word, slot 1 the read/write timing word and slot 2 the write timing word. The same port reads any of these words back combinationally. Host requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole external cycle and for any turnaround gap, so the requester must hold its request until it is taken. Each accepted request returns exactly one single-cycle `rsp_valid` pulse with no back-pressure, so the requester must always be able to take it.

The data bus is split into an output, an output enable and an input, so the pad ring can build the tristate. Every phase length is counted in cycles of `clk`.

Top module: `asm_timing_seq`

## Requirements
- R1: After reset, `req_ready` is high, `rsp_valid` is low, and all four strobes (`mem_cs_n`, `mem_oe_n`, `mem_we_n`, `mem_adv_n`) are high. Every timing word reads back as 0x0FFFFFFF and every control word reads back as 0.
- R2: A timing word holds address setup in bits [3:0], address hold in [7:4], data setup in [15:8] and turnaround in [19:16]. A field value N gives max(N,1) cycles. Chip select is low for exactly setup + hold + data cycles, and hold counts only on a multiplexed bus.
- R3: Control bit 1 selects the multiplexed bus. On that bus `mem_adv_n` is low for exactly the setup cycles. On a separate bus `mem_adv_n` never falls and there is no hold phase.
- R4: On a multiplexed bus the data lines drive the low address bits during setup and hold. The write data is driven only while `mem_we_n` is low. The data lines are released whenever `mem_oe_n` is low, and the two strobes are never low together.
- R5: Control bit 4 selects a 16-bit device. Then `mem_addr` is the request address shifted right by one, and read data is the full bus. With the bit clear, `mem_addr` is the request address unchanged, writes drive only the low byte, and reads return the low byte zero-extended.
- R6: Read data is captured on the last data-setup cycle. `rsp_valid` rises in the cycle after chip select goes high, that is setup + hold + data + 1 cycles after the handshake edge.
- R7: When control bit 14 is set, writes take their setup, hold and data lengths from the write timing word (slot 2), and reads keep using slot 1. When it is clear, both reads and writes use slot 1.
- R8: Storing a control word with bit 14 clear forces slot 2 to 0x0FFFFFFF. While bit 14 is clear, stores to slot 2 are ignored.
- R9: When control bit 12 is clear, a write gets `rsp_valid` with `rsp_err` high one cycle after the handshake, and no strobe falls.
- R10: A request to a region whose control bit 0 is clear gets an error response one cycle after the handshake, with no bus activity.
- R11: After a read on a multiplexed bus, `req_ready` stays low for exactly the turnaround field's value of cycles, starting with the response cycle. After writes, or on a separate bus, there is no gap.
- R12: Storing a control word whose type field, bits [3:2], equals 2 (NOR) sets bit 6, the flash-access enable, in the stored word.
- R13: `req_ready` is low in every cycle where chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Store cfg_wdata into the selected word |
| cfg_region | input | 2 | Region of the configuration access |
| cfg_slot | input | 2 | 0 control, 1 read/write timing, 2 write timing |
| cfg_wdata | input | 32 | Word to store |
| cfg_rdata | output | 32 | Selected word, combinational |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 write, 0 read |
| req_region | input | 2 | Target region |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was refused |
| rsp_rdata | output | 16 | Read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address valid (latch), active low |
| mem_addr | output | 24 | Memory address |
| mem_dq_o | output | 16 | Data/address lines out |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data lines in |

## Verification
The bench sweeps setup, hold and data lengths from zero upward. A design that did not clamp a zero field to one cycle would shorten chip select or hang its counter. The sweep covers both bus kinds, both widths and both directions. This exposes a hold phase leaking onto the separate bus, address lines left driven while output enable is low, and a missing address shift or byte mask. Extended mode is toggled so that reads and writes get different lengths, which catches writes that read slot 1 by mistake. Each turnaround gap is measured against the programmed value, and a gap after writes or on a separate bus counts as an error. Disabled writes and disabled regions must answer in one cycle with no strobe.

// File: rtl/asm_pkg.sv
package asm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HOLD,
    PH_DATA,
    PH_TURN
  } phase_t;

  // control word bit positions
  localparam int CB_EN    = 0;
  localparam int CB_MUX   = 1;
  localparam int CB_TYLO  = 2;
  localparam int CB_WIDE  = 4;
  localparam int CB_FLASH = 6;
  localparam int CB_WREN  = 12;
  localparam int CB_EXT   = 14;

  localparam logic [1:0]  MT_NOR = 2'd2;
  localparam logic [31:0] TW_OFF = 32'h0FFF_FFFF;

  typedef struct packed {
    logic [3:0] setup;
    logic [3:0] hold;
    logic [7:0] data;
    logic [3:0] turn;
  } tim_t;

  typedef struct packed {
    logic en;
    logic mux;
    logic wide;
    logic wren;
    logic ext;
  } ctl_t;

  function automatic tim_t unpack_tim(input logic [31:0] w);
    tim_t t;
    t.setup = w[3:0];
    t.hold  = w[7:4];
    t.data  = w[15:8];
    t.turn  = w[19:16];
    return t;
  endfunction

  function automatic ctl_t unpack_ctl(input logic [31:0] w);
    ctl_t c;
    c.en   = w[CB_EN];
    c.mux  = w[CB_MUX];
    c.wide = w[CB_WIDE];
    c.wren = w[CB_WREN];
    c.ext  = w[CB_EXT];
    return c;
  endfunction

  // counter load for a phase of max(v,1) cycles
  function automatic logic [7:0] ph_load(input logic [7:0] v);
    return (v == 8'd0) ? 8'd0 : v - 8'd1;
  endfunction

endpackage

// File: rtl/asm_cfg_bank.sv
module asm_cfg_bank
  import asm_pkg::*;
#(
  parameter int NREG = 4,
  parameter int RW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [RW-1:0] cfg_region,
  input  logic [1:0]    cfg_slot,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [RW-1:0] lk_region,
  output logic [31:0]   lk_ctrl,
  output logic [31:0]   lk_rwt,
  output logic [31:0]   lk_wt
);

  logic [31:0] ctrl_q [NREG];
  logic [31:0] rwt_q  [NREG];
  logic [31:0] wt_q   [NREG];

  function automatic logic [31:0] ctrl_fix(input logic [31:0] w);
    logic [31:0] r;
    r = w;
    if (w[CB_TYLO+1:CB_TYLO] == MT_NOR) r[CB_FLASH] = 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NREG; g++) begin
        ctrl_q[g] <= '0;
        rwt_q[g]  <= TW_OFF;
        wt_q[g]   <= TW_OFF;
      end
    end else if (cfg_we) begin
      for (int g = 0; g < NREG; g++) begin
        if (cfg_region == RW'(g)) begin
          case (cfg_slot)
            2'd0: begin
              ctrl_q[g] <= ctrl_fix(cfg_wdata);
              if (!cfg_wdata[CB_EXT]) wt_q[g] <= TW_OFF;
            end
            2'd1: rwt_q[g] <= cfg_wdata;
            2'd2: if (ctrl_q[g][CB_EXT]) wt_q[g] <= cfg_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (cfg_slot)
      2'd0:    cfg_rdata = ctrl_q[cfg_region];
      2'd1:    cfg_rdata = rwt_q[cfg_region];
      2'd2:    cfg_rdata = wt_q[cfg_region];
      default: cfg_rdata = '0;
    endcase
  end

  assign lk_ctrl = ctrl_q[lk_region];
  assign lk_rwt  = rwt_q[lk_region];
  assign lk_wt   = wt_q[lk_region];

endmodule

// File: rtl/asm_phase_fsm.sv
module asm_phase_fsm
  import asm_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [31:0]   lk_ctrl,
  input  logic [31:0]   lk_rwt,
  input  logic [31:0]   lk_wt,
  input  logic [DW-1:0] mem_dq_i,
  output phase_t        phase,
  output logic          acc_write,
  output logic          acc_mux,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata
);

  localparam logic [DW-1:0] LO_MASK = DW'(8'hFF);

  ctl_t        c_in;
  tim_t        t_in;
  tim_t        acc_t;
  logic        acc_wide;
  logic        hs;
  logic        refuse;
  logic [7:0]  cnt;
  logic [DW-1:0] rd_val;

  assign c_in      = unpack_ctl(lk_ctrl);
  assign t_in      = (req_write && c_in.ext) ? unpack_tim(lk_wt) : unpack_tim(lk_rwt);
  assign req_ready = (phase == PH_IDLE);
  assign hs        = req_valid && req_ready;
  assign refuse    = !c_in.en || (req_write && !c_in.wren);
  assign rd_val    = acc_wide ? mem_dq_i : (mem_dq_i & LO_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      acc_t     <= '0;
      acc_write <= 1'b0;
      acc_mux   <= 1'b0;
      acc_wide  <= 1'b0;
      acc_addr  <= '0;
      acc_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (hs) begin
            if (refuse) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= '0;
            end else begin
              acc_t     <= t_in;
              acc_write <= req_write;
              acc_mux   <= c_in.mux;
              acc_wide  <= c_in.wide;
              acc_addr  <= c_in.wide ? (req_addr >> 1) : req_addr;
              acc_wdata <= c_in.wide ? req_wdata : (req_wdata & LO_MASK);
              cnt       <= ph_load({4'd0, t_in.setup});
              phase     <= PH_SETUP;
            end
          end
        end
        PH_SETUP: begin
          if (cnt != 8'd0) begin
            cnt <= cnt - 8'd1;
          end else if (acc_mux) begin
            cnt   <= ph_load({4'd0, acc_t.hold});
            phase <= PH_HOLD;
          end else begin
            cnt   <= ph_load(acc_t.data);
            phase <= PH_DATA;
          end
        end
        PH_HOLD: begin
          if (cnt != 8'd0) begin
            cnt <= cnt - 8'd1;
          end else begin
            cnt   <= ph_load(acc_t.data);
            phase <= PH_DATA;
          end
        end
        PH_DATA: begin
          if (cnt != 8'd0) begin
            cnt <= cnt - 8'd1;
          end else begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_rdata <= acc_write ? '0 : rd_val;
            if (!acc_write && acc_mux && acc_t.turn != 4'd0) begin
              cnt   <= {4'd0, acc_t.turn} - 8'd1;
              phase <= PH_TURN;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        PH_TURN: begin
          if (cnt != 8'd0) cnt <= cnt - 8'd1;
          else             phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/asm_bus_drv.sv
module asm_bus_drv
  import asm_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  phase_t        phase,
  input  logic          acc_write,
  input  logic          acc_mux,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_adv_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe
);

  logic in_addr;
  logic in_data;

  assign in_addr = (phase == PH_SETUP) || (phase == PH_HOLD);
  assign in_data = (phase == PH_DATA);

  always_comb begin
    mem_cs_n  = !(in_addr || in_data);
    mem_adv_n = !(phase == PH_SETUP && acc_mux);
    mem_oe_n  = !(in_data && !acc_write);
    mem_we_n  = !(in_data && acc_write);
    mem_addr  = acc_addr;
    if (in_addr && acc_mux) begin
      mem_dq_oe = 1'b1;
      mem_dq_o  = DW'(acc_addr);
    end else if (in_data && acc_write) begin
      mem_dq_oe = 1'b1;
      mem_dq_o  = acc_wdata;
    end else begin
      mem_dq_oe = 1'b0;
      mem_dq_o  = '0;
    end
  end

endmodule

// File: rtl/asm_timing_seq.sv
module asm_timing_seq
  import asm_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 24,
  parameter int DW   = 16,
  parameter int RW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [RW-1:0] cfg_region,
  input  logic [1:0]    cfg_slot,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [RW-1:0] req_region,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_adv_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  logic [31:0]   lk_ctrl, lk_rwt, lk_wt;
  phase_t        phase;
  logic          acc_write, acc_mux;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_wdata;

  asm_cfg_bank #(.NREG(NREG), .RW(RW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_slot(cfg_slot),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lk_region(req_region), .lk_ctrl(lk_ctrl), .lk_rwt(lk_rwt), .lk_wt(lk_wt)
  );

  asm_phase_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .lk_ctrl(lk_ctrl), .lk_rwt(lk_rwt), .lk_wt(lk_wt),
    .mem_dq_i(mem_dq_i), .phase(phase),
    .acc_write(acc_write), .acc_mux(acc_mux),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  asm_bus_drv #(.AW(AW), .DW(DW)) u_drv (
    .phase(phase), .acc_write(acc_write), .acc_mux(acc_mux),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_adv_n(mem_adv_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
  );

endmodule

// File: rtl/asm_checker.sv
module asm_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic oe_n,
  input logic we_n,
  input logic adv_n,
  input logic dq_oe,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_err
);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  p_read_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);

  p_write_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  p_adv_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |-> !cs_n);

  p_busy_not_ready_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);

  p_err_no_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> cs_n);

  p_rsp_after_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> ($past(!cs_n) && cs_n));

endmodule

bind asm_timing_seq asm_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .adv_n(mem_adv_n),
  .dq_oe(mem_dq_oe), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err)
);

// File: tb/test_asm_timing_seq.sv
module test_asm_timing_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_region = '0;
  logic [1:0]  cfg_slot = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_region = '0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
  logic [23:0] mem_addr;
  logic [15:0] mem_dq_o, mem_dq_i;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign mem_dq_i = mem_addr[15:0] ^ 16'hA5C3;

  asm_timing_seq i_asm_timing_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_slot(cfg_slot),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_region(req_region), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_adv_n(mem_adv_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(bit en, bit mux, logic [1:0] ty, bit wide, bit wren, bit ext);
    return 32'(en) | (32'(mux) << 1) | (32'(ty) << 2) | (32'(wide) << 4) |
           (32'(wren) << 12) | (32'(ext) << 14);
  endfunction

  function automatic logic [31:0] mk_tim(int s, int h, int d, int t);
    return 32'(s) | (32'(h) << 4) | (32'(d) << 8) | (32'(t) << 16);
  endfunction

  function automatic int m1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic cfg_put(input logic [1:0] rg, input logic [1:0] sl, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_region = rg; cfg_slot = sl; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_get(input logic [1:0] rg, input logic [1:0] sl, output logic [31:0] d);
    @(negedge clk);
    cfg_region = rg; cfg_slot = sl;
    #1 d = cfg_rdata;
  endtask

  // one access; returns observed counts
  task automatic run_acc(input bit wr, input logic [1:0] rg, input logic [23:0] a,
                         input logic [15:0] wd, input logic [23:0] exp_ma,
                         input logic [15:0] exp_wd,
                         output int lat, output int ncs, output int nadv,
                         output int nturn, output bit bus_ok, output bit err,
                         output logic [15:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_region = rg; req_addr = a; req_wdata = wd;
    lat = 0; ncs = 0; nadv = 0; nturn = 0; bus_ok = 1; err = 0; rd = '0;
    for (int k = 1; k < 80; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (!mem_cs_n) begin
        ncs++;
        if (req_ready) bus_ok = 0;
        if (mem_addr != exp_ma) bus_ok = 0;
      end
      if (!mem_adv_n) begin
        nadv++;
        if (!mem_dq_oe || mem_dq_o != exp_ma[15:0]) bus_ok = 0;
      end
      if (!mem_we_n && (!mem_dq_oe || mem_dq_o != exp_wd)) bus_ok = 0;
      if (!mem_oe_n && mem_dq_oe) bus_ok = 0;
      if (!mem_oe_n && !mem_we_n) bus_ok = 0;
      if (rsp_valid) begin
        lat = k; err = rsp_err; rd = rsp_rdata;
        break;
      end
    end
    while (!req_ready && nturn < 40) begin
      nturn++;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] rb;
    int lat, ncs, nadv, nturn;
    bit bus_ok, err;
    logic [15:0] rd;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 ready/rsp", {req_ready, rsp_valid}, 2'b10);
    chk({mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n} === 4'hF, "R1 strobes",
        {mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n}, 4'hF);
    rst_n = 1'b1;
    cfg_get(2'd3, 2'd1, rb); chk(rb == 32'h0FFFFFFF, "R1 timing reset", rb, 32'h0FFFFFFF);
    cfg_get(2'd2, 2'd0, rb); chk(rb == 32'h0, "R1 ctrl reset", rb, 0);

    // R12 NOR type sets flash enable
    cfg_put(2'd2, 2'd0, mk_ctrl(1, 0, 2'd2, 0, 1, 0));
    cfg_get(2'd2, 2'd0, rb);
    chk(rb[6] == 1'b1, "R12 flash bit set", rb, mk_ctrl(1, 0, 2'd2, 0, 1, 0) | 32'h40);
    cfg_put(2'd2, 2'd0, mk_ctrl(1, 0, 2'd0, 0, 1, 0));
    cfg_get(2'd2, 2'd0, rb);
    chk(rb[6] == 1'b0, "R12 flash bit clear for SRAM", rb, mk_ctrl(1, 0, 2'd0, 0, 1, 0));

    // R8 forced write word and ignored slot-2 store
    cfg_put(2'd0, 2'd0, mk_ctrl(1, 0, 0, 0, 1, 1));
    cfg_put(2'd0, 2'd2, 32'h0000_1234);
    cfg_get(2'd0, 2'd2, rb); chk(rb == 32'h1234, "R8 slot2 stored with ext", rb, 32'h1234);
    cfg_put(2'd0, 2'd0, mk_ctrl(1, 0, 0, 0, 1, 0));
    cfg_get(2'd0, 2'd2, rb); chk(rb == 32'h0FFFFFFF, "R8 forced on ext clear", rb, 32'h0FFFFFFF);
    cfg_put(2'd0, 2'd2, 32'h0000_0555);
    cfg_get(2'd0, 2'd2, rb); chk(rb == 32'h0FFFFFFF, "R8 slot2 ignored", rb, 32'h0FFFFFFF);

    // R9 write disabled
    cfg_put(2'd3, 2'd0, mk_ctrl(1, 1, 0, 1, 0, 0));
    cfg_put(2'd3, 2'd1, mk_tim(2, 2, 2, 3));
    run_acc(1, 2'd3, 24'h10, 16'hBEEF, 24'h8, 16'hBEEF, lat, ncs, nadv, nturn, bus_ok, err, rd);
    chk(lat == 1 && err, "R9 write refused", {lat[7:0], 7'd0, err}, 16'h0101);
    chk(ncs == 0 && nturn == 0, "R9 no bus activity", ncs, 0);
    // read still allowed on that region
    run_acc(0, 2'd3, 24'h10, 16'h0, 24'h8, 16'h0, lat, ncs, nadv, nturn, bus_ok, err, rd);
    chk(!err && ncs == 6, "R9 read allowed", ncs, 6);

    // R10 region disabled
    cfg_put(2'd2, 2'd0, mk_ctrl(0, 0, 0, 0, 1, 0));
    run_acc(0, 2'd2, 24'h20, 16'h0, 24'h20, 16'h0, lat, ncs, nadv, nturn, bus_ok, err, rd);
    chk(lat == 1 && err && ncs == 0, "R10 disabled region", {lat[7:0], 7'd0, err}, 16'h0101);

    // sweep: R2 R3 R4 R5 R6 R7 R11 R13
    for (int mx = 0; mx < 2; mx++)
      for (int wd = 0; wd < 2; wd++)
        for (int s = 0; s < 4; s++)
          for (int h = 0; h < 3; h++)
            for (int d = 0; d < 4; d++) begin
              int t, es, eh, ed, ws, wh, wdd;
              bit ext;
              logic [23:0] a, ema;
              logic [15:0] wdat, ewd, erd;
              t = (s + d) % 4;
              ext = s[0];
              ws = 3 - s; wh = 2 - h; wdd = 3 - d;
              cfg_put(2'd1, 2'd0, mk_ctrl(1, mx[0], 0, wd[0], 1, ext));
              cfg_put(2'd1, 2'd1, mk_tim(s, h, d, t));
              if (ext) cfg_put(2'd1, 2'd2, mk_tim(ws, wh, wdd, 0));
              a = 24'h3000 + 24'(s * 97 + h * 13 + d * 7 + mx * 5 + wd);
              ema = wd ? (a >> 1) : a;
              for (int wr = 0; wr < 2; wr++) begin
                wdat = 16'h5A00 ^ 16'(s * 4099 + d * 257 + h * 31 + wr);
                ewd = wd ? wdat : (wdat & 16'h00FF);
                erd = wd ? (ema[15:0] ^ 16'hA5C3) : ((ema[15:0] ^ 16'hA5C3) & 16'h00FF);
                if (wr && ext) begin es = m1(ws); eh = m1(wh); ed = m1(wdd); end
                else begin es = m1(s); eh = m1(h); ed = m1(d); end
                if (!mx) eh = 0;
                run_acc(wr[0], 2'd1, a, wdat, ema, ewd, lat, ncs, nadv, nturn, bus_ok, err, rd);
                chk(ncs == es + eh + ed, wr ? "R2 R7 write cs length" : "R2 read cs length",
                    ncs, es + eh + ed);
                chk(nadv == (mx ? es : 0), "R3 adv length", nadv, mx ? es : 0);
                chk(lat == es + eh + ed + 1 && !err, "R6 response cycle", lat, es + eh + ed + 1);
                chk(bus_ok, "R4 R5 R13 bus contents", bus_ok, 1);
                if (!wr) chk(rd == erd, "R5 R6 read data", rd, erd);
                chk(nturn == ((!wr && mx) ? t : 0), "R11 turnaround", nturn, (!wr && mx) ? t : 0);
              end
            end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule